// File: doc/BRIEF.md
# Parallel Quadratic-Permutation Interleaver Address Generator

This block produces turbo-decoder interleaver addresses for a permutation of the form A(x) = (f1·x + f2·x²) mod K. It produces several addresses per clock, one per lane (eight by default), so that each of eight parallel soft-in/soft-out decoder units can fetch data from its own contiguous segment of the block. Lane i covers the x values i·K/8 to (i+1)·K/8 − 1 in ascending order.

The block uses no multiplier and no divider. Each lane keeps two registers, the current address A(x) and the current increment g(x). Every cycle it updates them with modular additions: A(x+1) = (A(x) + g(x)) mod K and g(x+1) = (g(x) + 2·f2) mod K. Each modular adder forms the raw sum and the sum minus K, and the sign of the difference chooses between them. The step 2·f2 mod K is computed once per block and shared by all lanes. Lane 0 derives its own first increment from f1 and f2. The other lanes take their first address and first increment from start-value ports, which an external table drives. A one-cycle start pulse loads everything. A valid flag then stays high for K/8 cycles.

Top module: `qpp_addr_gen`

## Requirements
- R1: While reset is high, and at the first sampling after reset, `valid_o` is 0 and every lane address in `addr_o` is 0.
- R2: In the cycle after `start_i` is sampled high, `valid_o` is 1 and lane i (bits i·13 to i·13+12 of `addr_o`) shows A(i·K/8). Lane 0 therefore shows 0. Lane i ≥ 1 shows the value on slice i−1 of `seed_addr_i`.
- R3: In each further valid cycle, every lane moves to its next x, and its address equals (f1·x + f2·x²) mod K computed directly. This includes steps whose raw sum reaches exactly K or more.
- R4: Lane 0 computes its first increment internally as (f1 + f2) mod K. Lane i ≥ 1 takes its first increment, (f1 + f2 + 2·f2·i·K/8) mod K, from slice i−1 of `seed_inc_i`.
- R5: `valid_o` stays high for exactly K/8 consecutive cycles and then falls. After it falls, `addr_o` holds its last value until the next start.
- R6: Every address shown while `valid_o` is high is below K. Over one whole block, the addresses from all lanes together form each value 0 to K−1 exactly once.
- R7: A start pulse that arrives while a block is still running abandons that block. The lanes restart from the new inputs, with the R2 timing.
- R8: `k_i`, `f1_i`, `f2_i`, `seed_addr_i` and `seed_inc_i` are sampled only in the start cycle. Changes to them during a block do not affect the addresses of that block.

Inputs must satisfy f1, f2 < K, with K a multiple of 8 and at most 6144.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that loads a new block |
| k_i | input | 13 | Block size K |
| f1_i | input | 13 | Linear coefficient f1 |
| f2_i | input | 13 | Quadratic coefficient f2 |
| seed_addr_i | input | 91 | First address of lanes 1..7, 13 bits per lane |
| seed_inc_i | input | 91 | First increment of lanes 1..7, 13 bits per lane |
| addr_o | output | 104 | Current address of lanes 0..7, 13 bits per lane |
| valid_o | output | 1 | High while `addr_o` carries a block's addresses |

## Verification
A wrong increment register does not show in the first valid cycle, because the first address comes straight from the seed. It shows in the second cycle, where the lane's address departs from the direct polynomial, and every later address is off as well. A wrong reduction shows as an address at or above K in the cycle after the bad sum, or as a duplicate in the per-block permutation tally. An error in the length counter shows as a valid run that is not exactly K/8 cycles long. The bench sweeps several block sizes, including the largest, and compares every lane in every cycle.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  localparam int unsigned QPP_AW    = 13;
  localparam int unsigned QPP_LANES = 8;

  function automatic int unsigned clog2_fn(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction
endpackage

// File: rtl/qpp_modadd.sv
// (a + b) mod k for a, b < k: form the sum and sum - k, and let the sign pick.
module qpp_modadd #(
  parameter int unsigned AW = 13
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic [AW-1:0] k,
  output logic [AW-1:0] y
);
  logic [AW:0]   sum;
  logic [AW+1:0] diff;

  always_comb begin
    sum  = {1'b0, a} + {1'b0, b};
    diff = {1'b0, sum} - {2'b00, k};
    y    = diff[AW+1] ? sum[AW-1:0] : diff[AW-1:0];
  end
endmodule

// File: rtl/qpp_lane.sv
module qpp_lane #(
  parameter int unsigned AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] k,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] a_init,
  input  logic [AW-1:0] g_init,
  output logic [AW-1:0] a_q
);
  logic [AW-1:0] g_q;
  logic [AW-1:0] a_next;
  logic [AW-1:0] g_next;

  qpp_modadd #(.AW(AW)) u_addr_add (.a(a_q), .b(g_q),  .k(k), .y(a_next));
  qpp_modadd #(.AW(AW)) u_inc_add  (.a(g_q), .b(step), .k(k), .y(g_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      g_q <= '0;
    end else if (load) begin
      a_q <= a_init;
      g_q <= g_init;
    end else if (adv) begin
      a_q <= a_next;
      g_q <= g_next;
    end
  end

  // R3: each advance applies the modular recursion to the previous state
  assert_recursion_R3: assert property (@(posedge clk) disable iff (rst)
    $past(adv) && !$past(load) && !$past(rst) |->
      ({1'b0, a_q} == (({1'b0, $past(a_q)} + {1'b0, $past(g_q)}) % {1'b0, k})));

  // R4: the increment register stays reduced below K once loaded
  assert_inc_range_R4: assert property (@(posedge clk) disable iff (rst)
    $past(load) && !$past(rst) && (k != '0) |-> (g_q < k));

  // R5: without load or advance, the lane holds its address
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(load) && !$past(adv) && !$past(rst) |-> $stable(a_q));
endmodule

// File: rtl/qpp_ctrl.sv
module qpp_ctrl #(
  parameter int unsigned AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] seg_len,
  output logic          valid,
  output logic          adv
);
  logic [AW-1:0] remaining;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= 1'b0;
      remaining <= '0;
    end else if (start) begin
      valid     <= (seg_len != '0);
      remaining <= seg_len;
    end else if (valid) begin
      if (remaining == AW'(1)) valid <= 1'b0;
      remaining <= remaining - AW'(1);
    end
  end

  // lanes advance on every valid cycle except the last, so they hold afterwards
  assign adv = valid && (remaining != AW'(1));

  // R2: a start with a non-empty segment opens a valid window
  assert_start_valid_R2: assert property (@(posedge clk) disable iff (rst)
    start && (seg_len != '0) |=> valid);

  // R5: valid can only rise because of a start
  assert_valid_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(start));
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen #(
  parameter int unsigned AW    = qpp_pkg::QPP_AW,
  parameter int unsigned LANES = qpp_pkg::QPP_LANES
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [AW-1:0]          k_i,
  input  logic [AW-1:0]          f1_i,
  input  logic [AW-1:0]          f2_i,
  input  logic [(LANES-1)*AW-1:0] seed_addr_i,
  input  logic [(LANES-1)*AW-1:0] seed_inc_i,
  output logic [LANES*AW-1:0]    addr_o,
  output logic                   valid_o
);
  localparam int unsigned LOG_L = qpp_pkg::clog2_fn(LANES);

  logic [AW-1:0] k_q;
  logic [AW-1:0] step_q;
  logic [AW-1:0] step_d;
  logic [AW-1:0] g0_d;
  logic [AW-1:0] seg_len;
  logic          adv;

  // shared by all lanes: 2*f2 mod K and lane 0's first increment
  qpp_modadd #(.AW(AW)) u_step_add (.a(f2_i), .b(f2_i), .k(k_i), .y(step_d));
  qpp_modadd #(.AW(AW)) u_g0_add   (.a(f1_i), .b(f2_i), .k(k_i), .y(g0_d));

  assign seg_len = k_i >> LOG_L;

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q    <= '0;
      step_q <= '0;
    end else if (start_i) begin
      k_q    <= k_i;
      step_q <= step_d;
    end
  end

  qpp_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start_i), .seg_len(seg_len),
    .valid(valid_o), .adv(adv)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [AW-1:0] a_init;
    logic [AW-1:0] g_init;
    logic [AW-1:0] a_lane;
    if (i == 0) begin : g_first
      assign a_init = '0;
      assign g_init = g0_d;
    end else begin : g_rest
      assign a_init = seed_addr_i[(i-1)*AW +: AW];
      assign g_init = seed_inc_i[(i-1)*AW +: AW];
    end

    qpp_lane #(.AW(AW)) u_lane (
      .clk(clk), .rst(rst), .load(start_i), .adv(adv),
      .k(k_q), .step(step_q), .a_init(a_init), .g_init(g_init),
      .a_q(a_lane)
    );
    assign addr_o[i*AW +: AW] = a_lane;

    // R6: each lane address lies below K while valid
    assert_addr_range_R6: assert property (@(posedge clk) disable iff (rst)
      valid_o && !$past(start_i) |-> (a_lane < k_q));
  end

  // R1: reset clears valid
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !valid_o);
endmodule

// File: tb/qpp_addr_gen_tb.sv
module qpp_addr_gen_tb;
  localparam int AW = 13;
  localparam int L  = 8;

  logic                clk = 0;
  logic                rst = 1;
  logic                start_i = 0;
  logic [AW-1:0]       k_i = '0, f1_i = '0, f2_i = '0;
  logic [(L-1)*AW-1:0] seed_addr_i = '0, seed_inc_i = '0;
  logic [L*AW-1:0]     addr_o;
  logic                valid_o;

  int checks = 0, fails = 0;
  bit done = 0;
  bit seen [0:6143];

  always #10 clk = ~clk;

  qpp_addr_gen u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .k_i(k_i), .f1_i(f1_i),
    .f2_i(f2_i), .seed_addr_i(seed_addr_i), .seed_inc_i(seed_inc_i),
    .addr_o(addr_o), .valid_o(valid_o)
  );

  function automatic int poly(int k, int f1, int f2, int x);
    longint v;
    v = (longint'(f1) * x + longint'(f2) * x * x) % k;
    return int'(v);
  endfunction

  function automatic int incr(int k, int f1, int f2, int x);
    longint v;
    v = (longint'(f1) + f2 + 2 * longint'(f2) * x) % k;
    return int'(v);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // stop_after < 0: run whole block; otherwise check that many cycles and leave it running
  task automatic run_block(int k, int f1, int f2, int stop_after, bit perturb, string tag);
    int seg, lim;
    bit dup;
    int cnt;
    seg = k / L;
    @(negedge clk);
    k_i = AW'(k); f1_i = AW'(f1); f2_i = AW'(f2);
    for (int i = 1; i < L; i++) begin
      seed_addr_i[(i-1)*AW +: AW] = AW'(poly(k, f1, f2, i * seg));
      seed_inc_i[(i-1)*AW +: AW]  = AW'(incr(k, f1, f2, i * seg));
    end
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int v = 0; v < 6144; v++) seen[v] = 0;
    dup = 0;
    lim = (stop_after < 0) ? seg : stop_after;
    for (int j = 0; j < lim; j++) begin
      check(valid_o == 1'b1, (j == 0) ? "R2" : "R5", int'(valid_o), 1);
      for (int i = 0; i < L; i++) begin
        int a, e;
        a = int'(addr_o[i*AW +: AW]);
        e = poly(k, f1, f2, i * seg + j);
        // R2 first cycle, R3 later, R8 when inputs were disturbed, R7 after a restart
        check(a == e, (j == 0) ? ((tag == "R7") ? "R7" : "R2")
                               : ((perturb) ? "R8" : "R3"), a, e);
        if (a < k) begin
          if (seen[a]) dup = 1;
          seen[a] = 1;
        end else dup = 1;
      end
      if (perturb && j == 0) begin
        k_i = 13'd1000; f1_i = 13'd17; f2_i = 13'd5;
        seed_addr_i = '1; seed_inc_i = '1;
      end
      @(negedge clk);
    end
    if (stop_after < 0) begin
      check(valid_o == 1'b0, "R5", int'(valid_o), 0);
      cnt = 0;
      for (int v = 0; v < k; v++) if (seen[v]) cnt++;
      check(!dup && cnt == k, "R6", cnt, k);
      // R5: addresses hold after the block ends (last x of each lane)
      repeat (2) @(negedge clk);
      for (int i = 0; i < L; i++) begin
        int a, e;
        a = int'(addr_o[i*AW +: AW]);
        e = poly(k, f1, f2, i * seg + seg - 1);
        check(a == e, "R5", a, e);
      end
      check(valid_o == 1'b0, "R5", int'(valid_o), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(valid_o == 1'b0, "R1", int'(valid_o), 0);
    check(addr_o == '0, "R1", int'(addr_o[AW-1:0]), 0);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(valid_o == 1'b0, "R1", int'(valid_o), 0);
    check(addr_o == '0, "R1", int'(addr_o[AW-1:0]), 0);

    // R4 is exercised through lane 0's second address in every block
    run_block(40,   3,   10,  -1, 0, "R3");
    run_block(48,   7,   12,  -1, 0, "R3");
    run_block(64,   7,   16,  -1, 0, "R4");
    run_block(104,  7,   26,  -1, 0, "R3");
    run_block(512,  31,  64,  -1, 0, "R6");
    run_block(1008, 55,  84,  -1, 0, "R3");
    run_block(6144, 263, 480, -1, 0, "R6");
    // R8: inputs disturbed during the block
    run_block(208,  27,  52,  -1, 1, "R8");
    // R7: restart in the middle of a block
    run_block(4096, 31,  64,  5,  0, "R3");
    run_block(120,  103, 90,  -1, 0, "R7");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule